// File: doc/BRIEF.md
# UDP/IP Receive Packet Filter

This block sits on the receive path of a network port. It takes a frame that arrives as a stream of 32-bit words, one word per valid cycle, and reads the Ethernet, IPv4 and UDP headers while they pass. Each header field is tested against the configured host MAC address, the host IPv4 address and the accepted protocol values. At the same pace the block accumulates the IPv4 header checksum and the UDP checksum. The UDP checksum covers the pseudo-header. The Ethernet CRC is computed by another block, which reports pass or fail alongside the final word.

Payload words are realigned from the 2-byte offset that the 42 bytes of headers leave behind. They are written into a block-RAM-style buffer as they arrive. They leave the block only after the frame end, once every test has passed. A one-cycle status pulse gives the verdict. It carries an accept bit, a flag for address-resolution frames and a 3-bit reason code for a drop.

Top module: `udp_rx_filter`

## Requirements
- R1: A frame is a run of valid words from the one marked start to the one marked end. Bytes are big-endian, so byte 0 sits in bits 31:24. A frame is 42+4n bytes with 1 <= n <= BUF_DEPTH. The low half of the end word is padding and is ignored. `stat_done` pulses for one cycle, in the cycle after the end word. The next frame starts only after the previous payload has been delivered, and no earlier than 8 idle cycles after an end word. All outputs are low after reset.
- R2: If the destination MAC (bytes 0-5) differs from `host_mac`, the frame is dropped with reason 1.
- R3: For EtherType (bytes 12-13), 0x0800 continues through the filter. 0x0806 sets `stat_arp` and drops with reason 2. Any other value drops with reason 2 and leaves `stat_arp` low.
- R4: If the IPv4 destination address (bytes 30-33) differs from `host_ip`, the frame is dropped with reason 3.
- R5: If the IPv4 protocol byte (byte 23) is not 17, the frame is dropped with reason 4.
- R6: If the UDP destination port (bytes 36-37) is not `UDP_PORT` (default 2025), the frame is dropped with reason 5.
- R7: The ones'-complement sum of the ten 16-bit halves of bytes 14-33 must fold to 0xFFFF. Otherwise the frame is dropped with reason 6.
- R8: The UDP sum must fold to 0xFFFF. It covers source IP, destination IP, the value 17, the UDP length, then the UDP header and payload. Otherwise the frame is dropped with reason 7. A transmitted UDP checksum of 0 skips this test.
- R9: With no header fault, `crc_ok` low on the end word drops the frame with reason 0.
- R10: When several faults are present, the reason is the lowest nonzero code among them. A CRC failure is reported only when no other fault is present.
- R11: An accepted frame reports `stat_accept`=1, reason 0 and `stat_arp`=0. Its n payload words follow on consecutive cycles starting one cycle after `stat_done`. Word k carries frame bytes 42+4k to 45+4k, and `pay_last` marks word n-1.
- R12: A dropped frame emits no payload word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Frame word present |
| in_sop | input | 1 | First word of a frame |
| in_eop | input | 1 | Last word of a frame |
| in_data | input | 32 | Frame word, big-endian |
| crc_ok | input | 1 | Ethernet CRC result, sampled with the end word |
| host_mac | input | 48 | Host MAC address |
| host_ip | input | 32 | Host IPv4 address |
| stat_done | output | 1 | Verdict pulse |
| stat_accept | output | 1 | Frame accepted |
| stat_arp | output | 1 | Frame carried the address-resolution EtherType |
| stat_reason | output | 3 | Drop reason code |
| pay_valid | output | 1 | Payload word present |
| pay_data | output | 32 | Realigned payload word |
| pay_last | output | 1 | Final payload word |

## Verification
Let P be the cycle after the clock edge that samples the end word. The verdict is due in cycle P, and payload word k is due in cycle P+1+k. Both come from one register stage after the end word, plus the buffer's registered read. For every frame the driver pushes the verdict and each payload word into queues, each tagged with its due cycle. The monitor samples on the falling edge and matches what it sees against both the value and the cycle number. A result that arrives early, arrives late or is not expected at all is therefore reported. One frame is built per fault type, plus a frame with several faults at once, and good frames with 1, 3, 4 and BUF_DEPTH payload words.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    RSN_CRC    = 3'd0,
    RSN_MAC    = 3'd1,
    RSN_ETYPE  = 3'd2,
    RSN_IPDST  = 3'd3,
    RSN_PROTO  = 3'd4,
    RSN_PORT   = 3'd5,
    RSN_IPSUM  = 3'd6,
    RSN_UDPSUM = 3'd7
  } rsn_e;

  localparam logic [15:0] ETH_IPV4  = 16'h0800;
  localparam logic [15:0] ETH_ARP   = 16'h0806;
  localparam logic [7:0]  PROTO_UDP = 8'd17;
  localparam int          PAY_WORD0 = 11;  // first word holding realigned payload

  // lowest nonzero fault index wins
  function automatic logic [2:0] pick_reason(input logic [7:1] f);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 7; i >= 1; i--) begin
      if (f[i]) r = 3'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/rxf_csum.sv
module rxf_csum #(
  parameter int ACC_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        en,
  input  logic        use_hi,
  input  logic        use_lo,
  input  logic [16:0] extra,
  input  logic [31:0] word,
  output logic [15:0] folded
);
  logic [ACC_W-1:0] acc, tot;
  logic [16:0]      f1;

  always_comb begin
    tot = (start ? '0 : acc)
        + (use_hi ? ACC_W'(word[31:16]) : '0)
        + (use_lo ? ACC_W'(word[15:0])  : '0)
        + ACC_W'(extra);
    f1     = {1'b0, tot[15:0]} + 17'(tot[ACC_W-1:16]);
    folded = f1[15:0] + 16'(f1[16]);
  end

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= tot;
  end
endmodule

// File: rtl/rxf_hdr.sv
module rxf_hdr import rxf_pkg::*; #(
  parameter int          IW   = 7,
  parameter logic [15:0] PORT = 16'd2025
) (
  input  logic [IW-1:0] idx,
  input  logic [31:0]   word,
  input  logic [47:0]   host_mac,
  input  logic [31:0]   host_ip,
  output logic [7:0]    det,
  output logic          is_arp
);
  always_comb begin
    det    = '0;
    is_arp = 1'b0;
    case (idx)
      IW'(0): det[RSN_MAC]   = word != host_mac[47:16];
      IW'(1): det[RSN_MAC]   = word[31:16] != host_mac[15:0];
      IW'(3): begin
        is_arp           = word[31:16] == ETH_ARP;
        det[RSN_ETYPE]   = word[31:16] != ETH_IPV4;
      end
      IW'(5): det[RSN_PROTO] = word[7:0] != PROTO_UDP;
      IW'(7): det[RSN_IPDST] = word[15:0] != host_ip[31:16];
      IW'(8): det[RSN_IPDST] = word[31:16] != host_ip[15:0];
      IW'(9): det[RSN_PORT]  = word[31:16] != PORT;
      default: ;
    endcase
  end
endmodule

// File: rtl/rxf_paybuf.sv
module rxf_paybuf #(
  parameter int DEPTH = 64,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          go,
  output logic          pay_valid,
  output logic [DW-1:0] pay_data,
  output logic          pay_last
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] wr_ptr, rd_ptr, cnt;
  logic          draining;
  logic          last_rd;

  assign last_rd = (rd_ptr + CW'(1)) == cnt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (draining && !go) pay_data <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cnt       <= '0;
      draining  <= 1'b0;
      pay_valid <= 1'b0;
      pay_last  <= 1'b0;
    end else begin
      if (clear)      wr_ptr <= '0;
      else if (wr_en) wr_ptr <= wr_ptr + CW'(1);
      pay_valid <= 1'b0;
      pay_last  <= 1'b0;
      if (go) begin
        draining <= 1'b1;
        rd_ptr   <= '0;
        cnt      <= wr_ptr + CW'(wr_en);
      end else if (draining) begin
        pay_valid <= 1'b1;
        pay_last  <= last_rd;
        rd_ptr    <= rd_ptr + CW'(1);
        if (last_rd) draining <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/udp_rx_filter.sv
module udp_rx_filter import rxf_pkg::*; #(
  parameter int          BUF_DEPTH = 64,
  parameter logic [15:0] UDP_PORT  = 16'd2025
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [31:0] in_data,
  input  logic        crc_ok,
  input  logic [47:0] host_mac,
  input  logic [31:0] host_ip,
  output logic        stat_done,
  output logic        stat_accept,
  output logic        stat_arp,
  output logic [2:0]  stat_reason,
  output logic        pay_valid,
  output logic [31:0] pay_data,
  output logic        pay_last
);
  localparam int IW = $clog2(BUF_DEPTH + PAY_WORD0 + 2);

  logic [IW-1:0] wc, idx;
  logic [15:0]   prev_lo, ip_sum, udp_sum;
  logic [7:0]    faults, det_hdr, det_all, faults_now;
  logic          arp_r, udp_zero, is_arp, arp_now;
  logic          frame_end, ip_bad, udp_bad, accept_now;
  logic [2:0]    rsn_now;

  assign frame_end = in_valid && in_eop;
  assign idx       = in_sop ? '0 : wc;

  rxf_hdr #(.IW(IW), .PORT(UDP_PORT)) u_hdr (
    .idx(idx), .word(in_data), .host_mac(host_mac), .host_ip(host_ip),
    .det(det_hdr), .is_arp(is_arp)
  );

  // IPv4 header: low half of word 3 through high half of word 8
  rxf_csum u_ipsum (
    .clk(clk), .rst(rst), .start(in_sop), .en(in_valid),
    .use_hi(idx >= IW'(4) && idx <= IW'(8)),
    .use_lo(idx >= IW'(3) && idx <= IW'(7)),
    .extra(17'd0), .word(in_data), .folded(ip_sum)
  );

  // UDP: addresses from word 6 onward, pseudo protocol and length at word 9
  rxf_csum u_udpsum (
    .clk(clk), .rst(rst), .start(in_sop), .en(in_valid),
    .use_hi(idx >= IW'(7)),
    .use_lo(idx >= IW'(6) && !in_eop),
    .extra((idx == IW'(9)) ? (17'(PROTO_UDP) + 17'(in_data[15:0])) : 17'd0),
    .word(in_data), .folded(udp_sum)
  );

  always_comb begin
    ip_bad  = in_valid && idx == IW'(8) && ip_sum != 16'hFFFF;
    udp_bad = frame_end && !udp_zero && udp_sum != 16'hFFFF;
    det_all = in_valid ? det_hdr : '0;
    det_all[RSN_IPSUM]  = det_all[RSN_IPSUM] | ip_bad;
    det_all[RSN_UDPSUM] = det_all[RSN_UDPSUM] | udp_bad;
    faults_now = (in_sop ? 8'd0 : faults) | det_all;
    rsn_now    = pick_reason(faults_now[7:1]);
    accept_now = (faults_now[7:1] == 7'd0) && crc_ok;
    arp_now    = (in_sop ? 1'b0 : arp_r) | (in_valid && is_arp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wc          <= '0;
      prev_lo     <= '0;
      faults      <= '0;
      arp_r       <= 1'b0;
      udp_zero    <= 1'b0;
      stat_done   <= 1'b0;
      stat_accept <= 1'b0;
      stat_arp    <= 1'b0;
      stat_reason <= 3'd0;
    end else begin
      stat_done <= frame_end;
      if (in_valid) begin
        wc      <= (idx == '1) ? idx : idx + IW'(1);
        prev_lo <= in_data[15:0];
        faults  <= faults_now;
        arp_r   <= arp_now;
        if (idx == IW'(10)) udp_zero <= in_data[31:16] == 16'h0000;
      end
      if (frame_end) begin
        stat_accept <= accept_now;
        stat_arp    <= arp_now;
        stat_reason <= rsn_now;
      end
    end
  end

  rxf_paybuf #(.DEPTH(BUF_DEPTH), .DW(32)) u_buf (
    .clk(clk), .rst(rst),
    .clear(in_valid && in_sop),
    .wr_en(in_valid && idx >= IW'(PAY_WORD0)),
    .wr_data({prev_lo, in_data[31:16]}),
    .go(frame_end && accept_now),
    .pay_valid(pay_valid), .pay_data(pay_data), .pay_last(pay_last)
  );
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_sop,
  input logic       in_eop,
  input logic       crc_ok,
  input logic       stat_done,
  input logic       stat_accept,
  input logic       stat_arp,
  input logic [2:0] stat_reason,
  input logic       pay_valid,
  input logic       pay_last
);
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    stat_done |-> $past(in_valid && in_eop)); // R1

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop) |-> !pay_valid); // R1

  AST_ARP_NEVER_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    (stat_done && stat_arp) |-> !stat_accept); // R3

  AST_CRC_FAIL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (stat_done && !$past(crc_ok)) |-> !stat_accept); // R9

  AST_ACCEPT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (stat_done && stat_accept) |-> (stat_reason == 3'd0 && !stat_arp)); // R11

  AST_LAST_IN_VALID: assert property (@(posedge clk) disable iff (rst)
    pay_last |-> pay_valid); // R11

  AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (rst)
    pay_last |=> !pay_valid); // R11

  AST_PAY_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(pay_valid) |-> $past(stat_done && stat_accept)); // R12
endmodule

bind udp_rx_filter rxf_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
  .crc_ok(crc_ok), .stat_done(stat_done), .stat_accept(stat_accept),
  .stat_arp(stat_arp), .stat_reason(stat_reason), .pay_valid(pay_valid),
  .pay_last(pay_last)
);

// File: tb/udp_rx_filter_test.sv
module udp_rx_filter_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          DEPTH      = 64;
  localparam logic [47:0] MY_MAC     = 48'h0211_2233_4455;
  localparam logic [31:0] MY_IP      = 32'hC0A8_0107;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst, in_valid, in_sop, in_eop, crc_ok;
  logic [31:0] in_data;
  logic        stat_done, stat_accept, stat_arp, pay_valid, pay_last;
  logic [2:0]  stat_reason;
  logic [31:0] pay_data;

  udp_rx_filter #(.BUF_DEPTH(DEPTH), .UDP_PORT(16'd2025)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .crc_ok(crc_ok), .host_mac(MY_MAC), .host_ip(MY_IP),
    .stat_done(stat_done), .stat_accept(stat_accept), .stat_arp(stat_arp),
    .stat_reason(stat_reason), .pay_valid(pay_valid), .pay_data(pay_data),
    .pay_last(pay_last)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, n_extra = 0;
  logic [7:0] fr [320];
  int flen;

  int          sq_cyc[$];
  logic [4:0]  sq_val[$];
  string       sq_tag[$];
  int          pq_cyc[$];
  logic [32:0] pq_val[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fold(input longint unsigned s);
    while ((s >> 16) != 0) s = (s & 64'hFFFF) + (s >> 16);
    return s[15:0];
  endfunction

  function automatic logic [15:0] bump(input logic [15:0] c);
    return (c == 16'hFFFF) ? 16'h0001 : c + 16'h0001;
  endfunction

  function automatic logic [15:0] half(input int at);
    return {fr[at], fr[at+1]};
  endfunction

  task automatic put16(input int at, input logic [15:0] v);
    fr[at] = v[15:8];
    fr[at+1] = v[7:0];
  endtask

  // umode: 0 good, 1 corrupt, 2 zero (skip)
  task automatic build(input logic [47:0] dmac, input logic [15:0] etype,
                       input logic [31:0] dip, input logic [7:0] proto,
                       input logic [15:0] dport, input int npay,
                       input bit ipbad, input int umode, input int seed);
    longint unsigned s;
    logic [15:0] c;
    flen = 42 + 4*npay;
    for (int i = 0; i < 320; i++) fr[i] = 8'h00;
    for (int i = 0; i < 6; i++) fr[i] = dmac[47-8*i -: 8];
    for (int i = 6; i < 12; i++) fr[i] = 8'(8'hA0 + i);
    put16(12, etype);
    fr[14] = 8'h45;
    put16(16, 16'(28 + 4*npay));
    put16(18, 16'(seed));
    fr[22] = 8'd64;
    fr[23] = proto;
    put16(26, 16'hC0A8); put16(28, 16'h0109);
    put16(30, dip[31:16]); put16(32, dip[15:0]);
    put16(34, 16'd5000);
    put16(36, dport);
    put16(38, 16'(8 + 4*npay));
    for (int i = 0; i < 4*npay; i++) fr[42+i] = 8'(seed*29 + i*13 + 5);
    s = 0;
    for (int i = 14; i < 34; i += 2) s += half(i);
    c = ~fold(s);
    if (ipbad) c = bump(c);
    put16(24, c);
    s = 64'd17 + half(38);
    for (int i = 26; i < 34; i += 2) s += half(i);
    for (int i = 34; i < flen; i += 2) s += half(i);
    c = ~fold(s);
    if (c == 16'h0000) c = 16'hFFFF;
    if (umode == 1) c = bump(c);
    if (umode == 2) c = 16'h0000;
    put16(40, c);
  endtask

  task automatic send(input bit crc, input bit acc, input bit arp,
                      input int rsn, input string tag);
    int nw, npay;
    nw = (flen + 3) / 4;
    npay = (flen - 42) / 4;
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (w == 0);
      in_eop   = (w == nw - 1);
      in_data  = {fr[4*w], fr[4*w+1], fr[4*w+2], fr[4*w+3]};
      crc_ok   = crc;
      if (w == nw - 1) begin
        sq_cyc.push_back(cyc + 1);
        sq_val.push_back({acc, arp, 3'(rsn)});
        sq_tag.push_back(tag);
        if (acc) begin
          for (int k = 0; k < npay; k++) begin
            pq_cyc.push_back(cyc + 2 + k);
            pq_val.push_back({k == npay - 1, fr[42+4*k], fr[43+4*k], fr[44+4*k], fr[45+4*k]});
          end
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0; crc_ok = 1'b0;
    repeat (npay + 8) @(negedge clk);
  endtask

  // monitor: pops expected items and compares value and cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (stat_done) begin
        if (sq_cyc.size() == 0) begin
          n_extra++;
          check(1'b0, "R1", "unexpected status", cyc, 0);
        end else begin
          int ec;
          logic [4:0] ev;
          string tg;
          ec = sq_cyc.pop_front(); ev = sq_val.pop_front(); tg = sq_tag.pop_front();
          check(cyc == ec && {stat_accept, stat_arp, stat_reason} == ev, tg,
                "status {cycle,accept,arp,reason}",
                (longint'(cyc) << 8) | {stat_accept, stat_arp, stat_reason},
                (longint'(ec) << 8) | ev);
        end
      end
      if (pay_valid) begin
        if (pq_cyc.size() == 0) begin
          n_extra++;
          check(1'b0, "R12", "unexpected payload word", pay_data, 0);
        end else begin
          int ec;
          logic [32:0] ev;
          ec = pq_cyc.pop_front(); ev = pq_val.pop_front();
          check(cyc == ec && {pay_last, pay_data} == ev, "R11",
                "payload {cycle,last,data}",
                (longint'(cyc) << 36) | {pay_last, pay_data},
                (longint'(ec) << 36) | ev);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_data = '0; crc_ok = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({stat_done, stat_accept, stat_arp, stat_reason, pay_valid, pay_last} == 0,
          "R1", "reset outputs",
          {stat_done, stat_accept, stat_arp, stat_reason, pay_valid, pay_last}, 0);

    build(MY_MAC, 16'h0800, MY_IP, 8'd17, 16'd2025, 4, 0, 0, 1);
    send(1, 1, 0, 0, "R11");
    build(MY_MAC, 16'h0800, MY_IP, 8'd17, 16'd2025, 1, 0, 0, 2);
    send(1, 1, 0, 0, "R1");
    build(MY_MAC ^ 48'h1, 16'h0800, MY_IP, 8'd17, 16'd2025, 2, 0, 0, 3);
    send(1, 0, 0, 1, "R2");
    build(MY_MAC, 16'h86DD, MY_IP, 8'd17, 16'd2025, 2, 0, 0, 4);
    send(1, 0, 0, 2, "R3");
    build(MY_MAC, 16'h0806, MY_IP, 8'd17, 16'd2025, 1, 0, 0, 5);
    send(1, 0, 1, 2, "R3");
    build(MY_MAC, 16'h0800, MY_IP ^ 32'h0001_0000, 8'd17, 16'd2025, 2, 0, 0, 6);
    send(1, 0, 0, 3, "R4");
    build(MY_MAC, 16'h0800, MY_IP, 8'd6, 16'd2025, 2, 0, 0, 7);
    send(1, 0, 0, 4, "R5");
    build(MY_MAC, 16'h0800, MY_IP, 8'd17, 16'd2024, 2, 0, 0, 8);
    send(1, 0, 0, 5, "R6");
    build(MY_MAC, 16'h0800, MY_IP, 8'd17, 16'd2025, 2, 1, 0, 9);
    send(1, 0, 0, 6, "R7");
    build(MY_MAC, 16'h0800, MY_IP, 8'd17, 16'd2025, 3, 0, 1, 10);
    send(1, 0, 0, 7, "R8");
    build(MY_MAC, 16'h0800, MY_IP, 8'd17, 16'd2025, 3, 0, 2, 11);
    send(1, 1, 0, 0, "R8");
    build(MY_MAC, 16'h0800, MY_IP, 8'd17, 16'd2025, 2, 0, 0, 12);
    send(0, 0, 0, 0, "R9");
    build(MY_MAC, 16'h0800, MY_IP, 8'd17, 16'd7, 2, 0, 1, 13);
    send(0, 0, 0, 5, "R10");
    build(MY_MAC ^ 48'h0100_0000_0000, 16'h0800, MY_IP, 8'd1, 16'd2025, 2, 1, 0, 14);
    send(1, 0, 0, 1, "R10");
    build(MY_MAC, 16'h0800, MY_IP, 8'd17, 16'd2025, DEPTH, 0, 0, 15);
    send(1, 1, 0, 0, "R11");

    repeat (10) @(negedge clk);
    check(sq_cyc.size() == 0 && pq_cyc.size() == 0, "R11", "pending expected items",
          sq_cyc.size() + pq_cyc.size(), 0);
    check(n_extra == 0, "R12", "unexpected outputs", n_extra, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule